// File: doc/BRIEF.md
# Black-Level Servo for a Digitised Pixel Stream

This block keeps the black level of a 12-bit pixel stream at a code chosen by software. Each line of a sensor starts with a run of shielded pixels. A clamp strobe marks that run. While the strobe is active, the block compares each sample with the target black code. It filters the difference in a fractional accumulator. The upper eight bits of the accumulator form the offset correction code, which in a full chip would drive an offset DAC ahead of the converter. Between strobe windows the correction does not change.

In this model the correction is taken away from the incoming samples digitally, and the corrected stream is the pixel output. A second strobe blanks the output to zero. The clamp strobe takes priority over blanking, so a clamp update is never disturbed by an overlapping blank. One configuration bit selects whether both strobes are active high or active low. When the servo is switched off, the stored target code becomes a fixed offset in place of the servo output.

Top module: `ob_level_servo`

## Requirements
- R1: After reset the target register holds 128, the correction output `corr_o` is 128 whether the servo is on or off, and `pix_o` is 0.
- R2: A clock edge with `target_we_i` high loads `target_i` into the target register. The new value is used from the following cycle.
- R3: The accumulator holds CODE_W+FRAC_W bits, and its upper CODE_W bits are `corr_o`. At a clock edge where the servo is enabled and the clamp strobe is active, the accumulator gains (y − target) · 2^(FRAC_W−SHIFT) in its own units. Here y is the corrected sample of that cycle. With the defaults (FRAC_W=6, SHIFT=2) the factor is 16, and `corr_o` shows the result one cycle later.
- R4: At a clock edge where the clamp strobe is inactive, or the servo is disabled, the accumulator keeps its value.
- R5: The accumulator saturates at 0 and at its all-ones value, so `corr_o` stops at 0 and at 255 and never wraps.
- R6: While `loop_en_i` is low, `corr_o` equals the target register, and the accumulator is held for when the servo is enabled again.
- R7: `pix_o` is max(`sample_i` − `corr_o`, 0), taken from the values in the cycle before.
- R8: If the blank strobe is active and the clamp strobe is not, `pix_o` is 0 in the next cycle. If both strobes are active, the sample passes as in R7 and the clamp update of R3 still takes place.
- R9: With `strobe_pol_i` = 1 a strobe is active when its pin is 1. With `strobe_pol_i` = 0 a strobe is active when its pin is 0. The bit applies to both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sample_i | input | 12 | Converter sample, one per clock |
| clamp_stb_i | input | 1 | Clamp strobe marking the shielded pixels (polarity set by `strobe_pol_i`) |
| blank_stb_i | input | 1 | Blanking strobe (polarity set by `strobe_pol_i`) |
| strobe_pol_i | input | 1 | 1: strobes active high, 0: active low |
| loop_en_i | input | 1 | 1: servo on, 0: fixed offset from the target register |
| target_we_i | input | 1 | Load strobe for the target register |
| target_i | input | 8 | New target black code |
| corr_o | output | 8 | Offset correction code |
| pix_o | output | 12 | Corrected, blanked sample |

## Verification
The corrected sample is registered once, so `pix_o` reflects the inputs one clock after they are applied. A clamp update reaches `corr_o` at that same edge. In the bench, inputs change on the falling edge. Just after the next rising edge the bench compares both outputs with a reference model, which it then advances. A target write shows first in the cycle after its edge, and the bench checks it there while the servo is off, so that `corr_o` exposes the register directly. Saturation, hold outside the window, the clamp-over-blank overlap and inverted strobe polarity are each driven on purpose. They are then mixed into a long seeded random run that uses line-shaped strobe windows.

// File: rtl/ob_servo_pkg.sv
package ob_servo_pkg;

    // Index of each strobe in the normalised strobe vector
    localparam int STB_CLAMP = 0;
    localparam int STB_BLANK = 1;
    localparam int STB_COUNT = 2;

    // Saturating unsigned subtraction: returns max(a - b, 0)
    function automatic logic [15:0] sat_sub16(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] diff;
        diff = {1'b0, a} - {1'b0, b};
        return diff[16] ? 16'd0 : diff[15:0];
    endfunction

endpackage

// File: rtl/ob_strobe_norm.sv
module ob_strobe_norm #(
    parameter int N = 2
) (
    input  logic         pol_i,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] act_o
);
    // Each strobe is turned into active-high form: pol_i = 1 keeps it, pol_i = 0 inverts it
    for (genvar g = 0; g < N; g++) begin : g_stb
        assign act_o[g] = pol_i ? raw_i[g] : ~raw_i[g];
    end
endmodule

// File: rtl/ob_pix_path.sv
module ob_pix_path
    import ob_servo_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int CODE_W   = 8
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [CODE_W-1:0]   corr_i,
    input  logic                clamp_i,
    input  logic                blank_i,
    output logic [SAMPLE_W-1:0] y_o,
    output logic [SAMPLE_W-1:0] pix_o
);
    logic [15:0] diff16;

    // The shared helper is 16 bits wide; the operands are widened to it
    always_comb begin
        diff16 = sat_sub16(16'(sample_i), 16'(corr_i));
        y_o    = diff16[SAMPLE_W-1:0];
        // Blanking only acts while the clamp strobe is inactive
        pix_o  = (blank_i && !clamp_i) ? '0 : y_o;
    end
endmodule

// File: rtl/ob_loop_filter.sv
module ob_loop_filter #(
    parameter int SAMPLE_W = 12,
    parameter int CODE_W   = 8,
    parameter int FRAC_W   = 6,
    parameter int SHIFT    = 2
) (
    input  logic [CODE_W+FRAC_W-1:0] acc_i,
    input  logic [SAMPLE_W-1:0]      y_i,
    input  logic [CODE_W-1:0]        target_i,
    output logic [CODE_W+FRAC_W-1:0] acc_o
);
    localparam int ACC_W = CODE_W + FRAC_W;
    localparam int ERR_W = SAMPLE_W + 2;
    localparam int UP_W  = (FRAC_W >= SHIFT) ? (FRAC_W - SHIFT) : 0;
    localparam int SUM_W = ((ACC_W > ERR_W + UP_W) ? ACC_W : ERR_W + UP_W) + 2;
    localparam logic signed [SUM_W-1:0] ACC_MAX_S = {{(SUM_W-ACC_W){1'b0}}, {ACC_W{1'b1}}};

    logic signed [ERR_W-1:0] err;
    logic signed [SUM_W-1:0] err_x;
    logic signed [SUM_W-1:0] step;
    logic signed [SUM_W-1:0] sum;

    assign err   = $signed({2'b00, y_i}) - $signed({{(ERR_W-CODE_W){1'b0}}, target_i});
    assign err_x = {{(SUM_W-ERR_W){err[ERR_W-1]}}, err};

    // The step is scaled up or down, depending on how SHIFT compares with FRAC_W
    if (FRAC_W >= SHIFT) begin : g_up
        assign step = err_x <<< (FRAC_W - SHIFT);
    end else begin : g_down
        assign step = err_x >>> (SHIFT - FRAC_W);
    end

    assign sum = $signed({{(SUM_W-ACC_W){1'b0}}, acc_i}) + step;

    always_comb begin
        if (sum[SUM_W-1]) begin
            acc_o = '0;
        end else if (sum > ACC_MAX_S) begin
            acc_o = '1;
        end else begin
            acc_o = sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/ob_level_servo.sv
module ob_level_servo
    import ob_servo_pkg::*;
#(
    parameter int SAMPLE_W    = 12,
    parameter int CODE_W      = 8,
    parameter int FRAC_W      = 6,
    parameter int SHIFT       = 2,
    parameter int RESET_LEVEL = 128
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                clamp_stb_i,
    input  logic                blank_stb_i,
    input  logic                strobe_pol_i,
    input  logic                loop_en_i,
    input  logic                target_we_i,
    input  logic [CODE_W-1:0]   target_i,
    output logic [CODE_W-1:0]   corr_o,
    output logic [SAMPLE_W-1:0] pix_o
);
    localparam int ACC_W = CODE_W + FRAC_W;
    localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(RESET_LEVEL);

    typedef struct packed {
        logic [ACC_W-1:0]    acc;
        logic [CODE_W-1:0]   target;
        logic [SAMPLE_W-1:0] pix;
    } state_t;

    state_t st_d, st_q;

    logic [STB_COUNT-1:0] stb_raw, stb_act;
    logic                 clamp_act, blank_act;
    logic [ACC_W-1:0]     acc_q, acc_step;
    logic [CODE_W-1:0]    target_q;
    logic [SAMPLE_W-1:0]  y_cur, pix_cur;

    assign stb_raw[STB_CLAMP] = clamp_stb_i;
    assign stb_raw[STB_BLANK] = blank_stb_i;

    ob_strobe_norm #(.N(STB_COUNT)) i_norm (
        .pol_i (strobe_pol_i),
        .raw_i (stb_raw),
        .act_o (stb_act)
    );

    assign clamp_act = stb_act[STB_CLAMP];
    assign blank_act = stb_act[STB_BLANK];
    assign acc_q     = st_q.acc;
    assign target_q  = st_q.target;

    // With the servo off, the stored target code acts as a fixed offset
    assign corr_o = loop_en_i ? acc_q[ACC_W-1 -: CODE_W] : target_q;

    ob_pix_path #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) i_pix (
        .sample_i (sample_i),
        .corr_i   (corr_o),
        .clamp_i  (clamp_act),
        .blank_i  (blank_act),
        .y_o      (y_cur),
        .pix_o    (pix_cur)
    );

    ob_loop_filter #(
        .SAMPLE_W (SAMPLE_W),
        .CODE_W   (CODE_W),
        .FRAC_W   (FRAC_W),
        .SHIFT    (SHIFT)
    ) i_filt (
        .acc_i    (acc_q),
        .y_i      (y_cur),
        .target_i (target_q),
        .acc_o    (acc_step)
    );

    always_comb begin
        st_d     = st_q;
        st_d.pix = pix_cur;
        if (target_we_i) begin
            st_d.target = target_i;
        end
        if (loop_en_i && clamp_act) begin
            st_d.acc = acc_step;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.acc    <= {RST_CODE, {FRAC_W{1'b0}}};
            st_q.target <= RST_CODE;
            st_q.pix    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o = st_q.pix;
endmodule

// File: rtl/ob_level_servo_chk.sv
module ob_level_servo_chk #(
    parameter int SAMPLE_W = 12,
    parameter int CODE_W   = 8,
    parameter int ACC_W    = 14
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                loop_en_i,
    input logic [SAMPLE_W-1:0] sample_i,
    input logic [SAMPLE_W-1:0] pix_o,
    input logic [CODE_W-1:0]   corr_o,
    input logic [CODE_W-1:0]   target_q,
    input logic [ACC_W-1:0]    acc_q,
    input logic                clamp_act,
    input logic                blank_act
);
    // R4: the accumulator keeps its value outside the clamp window or while the servo is off
    a_r4_hold_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clamp_act || !loop_en_i) |=> (acc_q == $past(acc_q)));

    // R6: while the servo is off, the offset changes only when the target changes
    a_r6_fixed_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!loop_en_i && $past(!loop_en_i) && $stable(target_q)) |-> $stable(corr_o));

    // R8: a blank without a clamp gives a zero output one cycle later
    a_r8_blank_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blank_act && !clamp_act) |=> (pix_o == '0));

    // R7: correction only ever lowers a sample
    a_r7_not_above_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (pix_o <= $past(sample_i)));
endmodule

bind ob_level_servo ob_level_servo_chk #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_W   (CODE_W),
    .ACC_W    (ACC_W)
) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .loop_en_i (loop_en_i),
    .sample_i  (sample_i),
    .pix_o     (pix_o),
    .corr_o    (corr_o),
    .target_q  (target_q),
    .acc_q     (acc_q),
    .clamp_act (clamp_act),
    .blank_act (blank_act)
);

// File: tb/test_ob_level_servo.sv
module test_ob_level_servo;
    localparam int CLK_PERIOD = 10;
    localparam int GAIN       = 16;     // 2^(FRAC_W-SHIFT) at defaults
    localparam int ACC_MAX    = 16383;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] sample = '0;
    logic        cs = 1'b0, bs = 1'b0, pol = 1'b1, en = 1'b0, we = 1'b0;
    logic [7:0]  tin = '0;
    logic [7:0]  corr;
    logic [11:0] pix;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;
    int m_acc, m_tgt, m_pix;

    always #(CLK_PERIOD/2) clk = ~clk;

    ob_level_servo i_ob_level_servo (
        .clk_i (clk), .rst_ni (rst_n), .sample_i (sample),
        .clamp_stb_i (cs), .blank_stb_i (bs), .strobe_pol_i (pol),
        .loop_en_i (en), .target_we_i (we), .target_i (tin),
        .corr_o (corr), .pix_o (pix)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_corr();
        return en ? (m_acc / 64) : m_tgt;
    endfunction

    // One clock: apply inputs on the falling edge, check just after the rising edge
    task automatic cyc(input int s, input bit c, input bit b, input bit e, input bit p,
                       input bit w, input int t);
        int corr_now, y, clamp_a, blank_a, nacc, nsum;
        string ctag, ptag;
        @(negedge clk);
        sample = 12'(s); cs = c; bs = b; en = e; pol = p; we = w; tin = 8'(t);
        clamp_a  = p ? c : !c;
        blank_a  = p ? b : !b;
        corr_now = model_corr();
        y        = (s > corr_now) ? s - corr_now : 0;
        m_pix    = (blank_a && !clamp_a) ? 0 : y;
        ptag     = (blank_a && !clamp_a) ? "R8" : (p ? "R7" : "R9");
        nacc     = m_acc;
        ctag     = e ? "R4" : "R6";
        if (e && clamp_a) begin
            nsum = m_acc + (y - m_tgt) * GAIN;
            ctag = p ? "R3" : "R9";
            if (nsum < 0) begin nsum = 0; ctag = "R5"; end
            if (nsum > ACC_MAX) begin nsum = ACC_MAX; ctag = "R5"; end
            nacc = nsum;
        end
        m_acc = nacc;
        if (w) m_tgt = t;
        @(posedge clk);
        #1;
        check(int'(corr) == model_corr(), ctag, int'(corr), model_corr());
        check(int'(pix) == m_pix, ptag, int'(pix), m_pix);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset values with the servo off and then on
        check(corr == 8'd128, "R1", int'(corr), 128);
        check(pix == 12'd0, "R1", int'(pix), 0);
        en = 1'b1; #1;
        check(corr == 8'd128, "R1", int'(corr), 128);
        en = 1'b0;
        m_acc = 128 * 64; m_tgt = 128; m_pix = 0;

        // R2: write the target while the servo is off, seen the next cycle
        cyc(300, 0, 0, 0, 1, 1, 64);
        check(corr == 8'd64, "R2", int'(corr), 64);
        cyc(300, 0, 0, 0, 1, 0, 0);

        // R3: a clamp window at a constant black of 200 converges towards 136
        for (int i = 0; i < 40; i++) cyc(200, 1, 0, 1, 1, 0, 0);
        check(corr >= 8'd135 && corr <= 8'd137, "R3", int'(corr), 136);

        // R4: outside the window the correction is held against large samples
        for (int i = 0; i < 10; i++) cyc(4000, 0, 0, 1, 1, 0, 0);
        check(corr >= 8'd135 && corr <= 8'd137, "R4", int'(corr), 136);

        // R5: the correction rises to 255 and stays there
        cyc(0, 0, 0, 1, 1, 1, 0);
        for (int i = 0; i < 30; i++) cyc(4095, 1, 0, 1, 1, 0, 0);
        check(corr == 8'd255, "R5", int'(corr), 255);
        // R5: the correction falls to 0 and stays there
        cyc(0, 0, 0, 1, 1, 1, 255);
        for (int i = 0; i < 40; i++) cyc(0, 1, 0, 1, 1, 0, 0);
        check(corr == 8'd0, "R5", int'(corr), 0);

        // R6: the servo is off; the clamp has no effect and the target is the offset
        cyc(0, 0, 0, 0, 1, 1, 50);
        for (int i = 0; i < 5; i++) cyc(900, 1, 0, 0, 1, 0, 0);
        check(corr == 8'd50, "R6", int'(corr), 50);
        cyc(900, 0, 0, 1, 1, 0, 0);
        check(corr == 8'd0, "R6", int'(corr), 0);

        // R8: blank alone, then blank overlapping the clamp
        cyc(700, 0, 1, 1, 1, 0, 0);
        check(pix == 12'd0, "R8", int'(pix), 0);
        cyc(700, 1, 1, 1, 1, 0, 0);
        check(pix != 12'd0, "R8", int'(pix), m_pix);

        // R9: active-low strobes; raw pins at 1 are idle
        for (int i = 0; i < 5; i++) cyc(600, 1, 1, 1, 0, 0, 0);
        for (int i = 0; i < 5; i++) cyc(600, 0, 1, 1, 0, 0, 0);
        cyc(600, 1, 0, 1, 0, 0, 0);
        check(pix == 12'd0, "R9", int'(pix), 0);

        // Random lines: clamp window, blanking, occasional writes, polarity and enable changes
        for (int ln = 0; ln < 60; ln++) begin
            bit p, e;
            int blk;
            p   = ($urandom % 4) != 0;
            e   = ($urandom % 8) != 0;
            blk = 150 + ($urandom % 300);
            for (int k = 0; k < 64; k++) begin
                bit c, b, w;
                int s;
                c = (k >= 4 && k < 28);
                b = (k >= 20 && k < 32);
                w = ($urandom % 97) == 0;
                s = c ? blk + int'($urandom % 16) : int'($urandom % 4096);
                cyc(s, p ? c : !c, p ? b : !b, e, p, w, int'($urandom % 256));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule